// File: doc/BRIEF.md
# Nested-Route Next-Hop Update Scanner

This block changes the next hop of one route that is already installed in a directly indexed forwarding table. Entries carry no prefix-length tag. Each entry holds a 2-bit boundary marker instead, and the markers of all installed routes nest like balanced brackets. The host names only the first entry of the route and the new next hop. The block then walks the table upward from that entry and tracks a relative nesting depth. It rewrites only the entries that sit at the route's own level, so any more specific routes nested inside it are left alone.

The table is a single-port synchronous memory outside the block. Lookups also use it. A lookup request always wins the port in its cycle, and the scanner waits for the next free cycle. Every entry the scanner visits is read and then, if it belongs to the route, written back with the same marker and the new next hop. The block pulses a completion flag when the route's closing entry has been handled. It raises an error flag if it runs past the last table entry while the route is still open.

Top module: `mkr_update_scanner`

## Requirements
- R1: An entry is {marker[1:0], next_hop[NH_W-1:0]}. Marker bit 0 means the entry opens a route and bit 1 means it closes one: 00 interior, 01 open, 10 close, 11 single-entry route.
- R2: `cmd_ready_o` is high only while no scan is running. A command is taken when `cmd_valid_i` and `cmd_ready_o` are both high, and `cmd_ready_o` is low in the following cycle.
- R3: Relative depth starts at 0. An opening marker adds one before the write decision. The entry is rewritten exactly when the depth is then 1. A closing marker subtracts one after the decision, never going below 0.
- R4: Entries of routes nested inside the target route keep their next hop.
- R5: The scan stops on the entry where the depth returns to 0, and `done_o` is high for exactly one cycle. A start entry with no opening marker therefore finishes with no write.
- R6: A rewrite carries the commanded next hop and the marker that was read from that entry.
- R7: Each write goes to the address the scanner last read (read-modify-write).
- R8: A cycle with `lk_valid_i` high gives the memory port to a read at `lk_addr_i`. `lk_rvalid_o` is high the next cycle, with `lk_nh_o` holding that entry's next hop.
- R9: If the last table entry is handled with the depth still above 0, the scan stops with `err_o` set and no `done_o`. `err_o` clears when the next command is accepted.
- R10: Lookups issued during a scan only delay it. The final table is the same as with no lookups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Update command present |
| cmd_ready_o | output | 1 | Scanner idle, command can be taken |
| cmd_start_i | input | IDX_W | First table entry of the route |
| cmd_nh_i | input | NH_W | New next hop |
| lk_valid_i | input | 1 | Lookup read request |
| lk_addr_i | input | IDX_W | Lookup table index |
| lk_rvalid_o | output | 1 | Lookup result valid |
| lk_nh_o | output | NH_W | Lookup next hop |
| mem_en_o | output | 1 | Memory access enable |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | IDX_W | Memory index |
| mem_wdata_o | output | NH_W+2 | Memory write entry |
| mem_rdata_i | input | NH_W+2 | Memory read entry, one cycle after the read |
| done_o | output | 1 | One-cycle scan completion pulse |
| err_o | output | 1 | Scan ran off the table end |

## Verification
Some properties are checked on every cycle. A lookup always owns the port and gets its result the next cycle. Each write reuses the marker just read, carries the commanded next hop and targets the address last read. The ready flag drops after a command is taken, the completion pulse lasts one cycle, and an error never coincides with completion. Other behaviour shows only in the bench's scenarios, where whole tables are compared against a model of the depth rule. These cover skipping of nested routes, where the scan stops, the single-entry and no-open starts, the run off the table end, and scans that are stalled by lookups.

// File: rtl/mkr_pkg.sv
`timescale 1ns/1ps
package mkr_pkg;
  typedef enum logic [1:0] {
    MK_MID    = 2'b00,
    MK_OPEN   = 2'b01,
    MK_CLOSE  = 2'b10,
    MK_SINGLE = 2'b11
  } mk_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WAIT = 2'd2,
    ST_WR   = 2'd3
  } st_e;

  function automatic logic mk_opens(logic [1:0] m);
    return m[0];
  endfunction

  function automatic logic mk_closes(logic [1:0] m);
    return m[1];
  endfunction
endpackage

// File: rtl/mkr_depth.sv
`timescale 1ns/1ps
module mkr_depth #(
  parameter int DEP_W = 6
) (
  input  logic [DEP_W-1:0] depth_i,
  input  logic [1:0]       mk_i,
  output logic             hit_o,
  output logic [DEP_W-1:0] depth_o,
  output logic             zero_o
);
  import mkr_pkg::*;

  logic [DEP_W-1:0] d_open;

  always_comb begin
    d_open  = depth_i + DEP_W'(mk_opens(mk_i));
    hit_o   = (d_open == DEP_W'(1));
    // close never drops below zero
    depth_o = (mk_closes(mk_i) && d_open != '0) ? d_open - DEP_W'(1) : d_open;
    zero_o  = (depth_o == '0);
  end
endmodule

// File: rtl/mkr_port_arb.sv
`timescale 1ns/1ps
module mkr_port_arb #(
  parameter int IDX_W = 10,
  parameter int ENT_W = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lk_valid_i,
  input  logic [IDX_W-1:0] lk_addr_i,
  input  logic             sc_req_i,
  input  logic             sc_we_i,
  input  logic [IDX_W-1:0] sc_addr_i,
  input  logic [ENT_W-1:0] sc_wdata_i,
  output logic             sc_gnt_o,
  output logic             mem_en_o,
  output logic             mem_we_o,
  output logic [IDX_W-1:0] mem_addr_o,
  output logic [ENT_W-1:0] mem_wdata_o,
  output logic             lk_rvalid_o
);
  logic rvalid_q;

  always_comb begin
    mem_wdata_o = sc_wdata_i;
    if (lk_valid_i) begin
      mem_en_o   = 1'b1;
      mem_we_o   = 1'b0;
      mem_addr_o = lk_addr_i;
    end else begin
      mem_en_o   = sc_req_i;
      mem_we_o   = sc_req_i & sc_we_i;
      mem_addr_o = sc_addr_i;
    end
    sc_gnt_o = sc_req_i & ~lk_valid_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rvalid_q <= 1'b0;
    else         rvalid_q <= lk_valid_i;
  end

  assign lk_rvalid_o = rvalid_q;
endmodule

// File: rtl/mkr_scan_ctrl.sv
`timescale 1ns/1ps
module mkr_scan_ctrl #(
  parameter int IDX_W = 10,
  parameter int NH_W  = 15,
  parameter int DEP_W = 6,
  localparam int ENT_W = NH_W + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic [IDX_W-1:0] cmd_start_i,
  input  logic [NH_W-1:0]  cmd_nh_i,
  output logic             cmd_ready_o,
  output logic             sc_req_o,
  output logic             sc_we_o,
  output logic [IDX_W-1:0] sc_addr_o,
  output logic [ENT_W-1:0] sc_wdata_o,
  input  logic             sc_gnt_i,
  input  logic [1:0]       rd_mk_i,
  output logic             done_o,
  output logic             err_o
);
  import mkr_pkg::*;

  localparam logic [IDX_W-1:0] LAST_IDX = '1;

  st_e              st_q;
  logic [IDX_W-1:0] addr_q;
  logic [NH_W-1:0]  nh_q;
  logic [DEP_W-1:0] depth_q;
  logic [1:0]       mk_q;
  logic             fin_q;
  logic             done_q;
  logic             err_q;

  logic             dep_hit;
  logic             dep_zero;
  logic [DEP_W-1:0] dep_next;
  logic             adv;
  logic             fin_sel;

  mkr_depth #(.DEP_W(DEP_W)) u_depth (
    .depth_i (depth_q),
    .mk_i    (rd_mk_i),
    .hit_o   (dep_hit),
    .depth_o (dep_next),
    .zero_o  (dep_zero)
  );

  always_comb begin
    cmd_ready_o = (st_q == ST_IDLE);
    sc_req_o    = (st_q == ST_RD) || (st_q == ST_WR);
    sc_we_o     = (st_q == ST_WR);
    sc_addr_o   = addr_q;
    sc_wdata_o  = {mk_q, nh_q};
    // step to the next entry: skipped entry in WAIT, or granted write
    adv         = ((st_q == ST_WAIT) && !dep_hit) || ((st_q == ST_WR) && sc_gnt_i);
    fin_sel     = (st_q == ST_WAIT) ? dep_zero : fin_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      nh_q    <= '0;
      depth_q <= '0;
      mk_q    <= '0;
      fin_q   <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (cmd_valid_i) begin
          addr_q  <= cmd_start_i;
          nh_q    <= cmd_nh_i;
          depth_q <= '0;
          err_q   <= 1'b0;
          st_q    <= ST_RD;
        end
        ST_RD: if (sc_gnt_i) st_q <= ST_WAIT;
        ST_WAIT: begin
          mk_q    <= rd_mk_i;
          depth_q <= dep_next;
          fin_q   <= dep_zero;
          if (dep_hit) st_q <= ST_WR;
        end
        ST_WR: ;
        default: st_q <= ST_IDLE;
      endcase
      if (adv) begin
        if (fin_sel) begin
          done_q <= 1'b1;
          st_q   <= ST_IDLE;
        end else if (addr_q == LAST_IDX) begin
          err_q  <= 1'b1;
          st_q   <= ST_IDLE;
        end else begin
          addr_q <= addr_q + IDX_W'(1);
          st_q   <= ST_RD;
        end
      end
    end
  end

  assign done_o = done_q;
  assign err_o  = err_q;
endmodule

// File: rtl/mkr_update_scanner.sv
`timescale 1ns/1ps
module mkr_update_scanner #(
  parameter int IDX_W = 10,
  parameter int NH_W  = 15,
  parameter int DEP_W = 6,
  localparam int ENT_W = NH_W + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  output logic             cmd_ready_o,
  input  logic [IDX_W-1:0] cmd_start_i,
  input  logic [NH_W-1:0]  cmd_nh_i,
  input  logic             lk_valid_i,
  input  logic [IDX_W-1:0] lk_addr_i,
  output logic             lk_rvalid_o,
  output logic [NH_W-1:0]  lk_nh_o,
  output logic             mem_en_o,
  output logic             mem_we_o,
  output logic [IDX_W-1:0] mem_addr_o,
  output logic [ENT_W-1:0] mem_wdata_o,
  input  logic [ENT_W-1:0] mem_rdata_i,
  output logic             done_o,
  output logic             err_o
);
  logic             sc_req;
  logic             sc_we;
  logic [IDX_W-1:0] sc_addr;
  logic [ENT_W-1:0] sc_wdata;
  logic             sc_gnt;

  mkr_scan_ctrl #(.IDX_W(IDX_W), .NH_W(NH_W), .DEP_W(DEP_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .cmd_start_i (cmd_start_i),
    .cmd_nh_i    (cmd_nh_i),
    .cmd_ready_o (cmd_ready_o),
    .sc_req_o    (sc_req),
    .sc_we_o     (sc_we),
    .sc_addr_o   (sc_addr),
    .sc_wdata_o  (sc_wdata),
    .sc_gnt_i    (sc_gnt),
    .rd_mk_i     (mem_rdata_i[ENT_W-1 -: 2]),
    .done_o      (done_o),
    .err_o       (err_o)
  );

  mkr_port_arb #(.IDX_W(IDX_W), .ENT_W(ENT_W)) u_arb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lk_valid_i  (lk_valid_i),
    .lk_addr_i   (lk_addr_i),
    .sc_req_i    (sc_req),
    .sc_we_i     (sc_we),
    .sc_addr_i   (sc_addr),
    .sc_wdata_i  (sc_wdata),
    .sc_gnt_o    (sc_gnt),
    .mem_en_o    (mem_en_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .lk_rvalid_o (lk_rvalid_o)
  );

  assign lk_nh_o = mem_rdata_i[NH_W-1:0];
endmodule

// File: rtl/mkr_update_scanner_chk.sv
`timescale 1ns/1ps
module mkr_update_scanner_chk #(
  parameter int IDX_W = 10,
  parameter int NH_W  = 15,
  parameter int DEP_W = 6,
  localparam int ENT_W = NH_W + 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cmd_valid_i,
  input logic             cmd_ready_o,
  input logic [IDX_W-1:0] cmd_start_i,
  input logic [NH_W-1:0]  cmd_nh_i,
  input logic             lk_valid_i,
  input logic [IDX_W-1:0] lk_addr_i,
  input logic             lk_rvalid_o,
  input logic [NH_W-1:0]  lk_nh_o,
  input logic             mem_en_o,
  input logic             mem_we_o,
  input logic [IDX_W-1:0] mem_addr_o,
  input logic [ENT_W-1:0] mem_wdata_o,
  input logic [ENT_W-1:0] mem_rdata_i,
  input logic             done_o,
  input logic             err_o
);
  logic [NH_W-1:0]  nh_cmd;
  logic [IDX_W-1:0] last_rd;
  logic             sc_rd_q;
  logic [1:0]       mk_seen;
  logic             sc_rd;

  assign sc_rd = mem_en_o && !mem_we_o && !lk_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nh_cmd  <= '0;
      last_rd <= '0;
      sc_rd_q <= 1'b0;
      mk_seen <= '0;
    end else begin
      if (cmd_valid_i && cmd_ready_o) nh_cmd <= cmd_nh_i;
      if (sc_rd) last_rd <= mem_addr_o;
      sc_rd_q <= sc_rd;
      if (sc_rd_q) mk_seen <= mem_rdata_i[ENT_W-1 -: 2];
    end
  end

  a_r8_lookup_owns_port: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_i |-> (mem_en_o && !mem_we_o && mem_addr_o == lk_addr_i));

  a_r8_lookup_returns: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_i |=> lk_rvalid_o);

  a_r6_nh_written: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_wdata_o[NH_W-1:0] == nh_cmd));

  a_r6_marker_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_wdata_o[ENT_W-1 -: 2] == mk_seen));

  a_r7_write_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_addr_o == last_rd));

  a_r2_busy_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_ready_o) |=> !cmd_ready_o);

  a_r2_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_ready_o && !lk_valid_i) |-> !mem_en_o);

  a_r5_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_err_not_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> !done_o);
endmodule

bind mkr_update_scanner mkr_update_scanner_chk #(
  .IDX_W(IDX_W), .NH_W(NH_W), .DEP_W(DEP_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_ready_o (cmd_ready_o),
  .cmd_start_i (cmd_start_i),
  .cmd_nh_i    (cmd_nh_i),
  .lk_valid_i  (lk_valid_i),
  .lk_addr_i   (lk_addr_i),
  .lk_rvalid_o (lk_rvalid_o),
  .lk_nh_o     (lk_nh_o),
  .mem_en_o    (mem_en_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_rdata_i (mem_rdata_i),
  .done_o      (done_o),
  .err_o       (err_o)
);

// File: tb/mkr_update_scanner_tb.sv
`timescale 1ns/1ps
module mkr_update_scanner_tb;
  localparam int IDX_W = 6;
  localparam int NH_W  = 15;
  localparam int DEP_W = 6;
  localparam int ENT_W = NH_W + 2;
  localparam int DEPTH = 1 << IDX_W;

  localparam int NV = 7;
  localparam int V_START [NV] = '{0, 4, 5, 16, 40, 33, 50};
  localparam int V_NH    [NV] = '{'h111, 'h222, 'h333, 'h444, 'h555, 'h666, 'h777};
  localparam int V_ERR   [NV] = '{0, 0, 0, 0, 0, 0, 1};

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic cmd_valid_i = 1'b0;
  logic cmd_ready_o;
  logic [IDX_W-1:0] cmd_start_i = '0;
  logic [NH_W-1:0] cmd_nh_i = '0;
  logic lk_valid_i = 1'b0;
  logic [IDX_W-1:0] lk_addr_i = '0;
  logic lk_rvalid_o;
  logic [NH_W-1:0] lk_nh_o;
  logic mem_en_o, mem_we_o;
  logic [IDX_W-1:0] mem_addr_o;
  logic [ENT_W-1:0] mem_wdata_o;
  logic [ENT_W-1:0] mem_rdata_i = '0;
  logic done_o, err_o;

  logic [ENT_W-1:0] mem [DEPTH];
  logic [ENT_W-1:0] exp_mem [DEPTH];
  int wr_cnt = 0;
  int n_total = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2 clk_i = ~clk_i;

  mkr_update_scanner #(.IDX_W(IDX_W), .NH_W(NH_W), .DEP_W(DEP_W)) u_dut (
    .clk_i, .rst_ni, .cmd_valid_i, .cmd_ready_o, .cmd_start_i, .cmd_nh_i,
    .lk_valid_i, .lk_addr_i, .lk_rvalid_o, .lk_nh_o,
    .mem_en_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_rdata_i,
    .done_o, .err_o
  );

  always @(posedge clk_i) begin
    if (mem_en_o) begin
      if (mem_we_o) begin
        mem[mem_addr_o] <= mem_wdata_o;
        wr_cnt <= wr_cnt + 1;
      end else begin
        mem_rdata_i <= mem[mem_addr_o];
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // R1 layout: {marker, nh}; 01 open, 10 close, 11 single, 00 interior
  task automatic init_table();
    for (int i = 0; i < DEPTH; i++) begin
      logic [1:0] m;
      case (i)
        0, 4, 16, 20, 50: m = 2'b01;
        7, 15, 22, 31:    m = 2'b10;
        5, 10, 40:        m = 2'b11;
        default:          m = 2'b00;
      endcase
      mem[i]     = {m, NH_W'(i + 'h100)};
      exp_mem[i] = {m, NH_W'(i + 'h100)};
    end
  endtask

  // model of R3/R5/R9 applied to exp_mem
  task automatic ref_apply(input int s, input logic [NH_W-1:0] nh, output bit e, output int nw);
    int d;
    d = 0; e = 0; nw = 0;
    for (int a = s; a < DEPTH; a++) begin
      logic [1:0] m;
      m = exp_mem[a][ENT_W-1 -: 2];
      if (m[0]) d++;
      if (d == 1) begin
        exp_mem[a][NH_W-1:0] = nh;
        nw++;
      end
      if (m[1] && d > 0) d--;
      if (d == 0) return;
    end
    e = 1;
  endtask

  function automatic int table_diffs();
    int n = 0;
    for (int i = 0; i < DEPTH; i++) if (mem[i] !== exp_mem[i]) n++;
    return n;
  endfunction

  task automatic issue(input int s, input int nh);
    @(negedge clk_i);
    cmd_valid_i = 1'b1;
    cmd_start_i = IDX_W'(s);
    cmd_nh_i    = NH_W'(nh);
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
    chk(cmd_ready_o == 1'b0, "R2", "ready after accept", cmd_ready_o, 0);
  endtask

  task automatic wait_end(output bit got_done, output bit got_err);
    got_done = 0; got_err = 0;
    for (int c = 0; c < 5000; c++) begin
      if (done_o) begin got_done = 1; break; end
      if (err_o)  begin got_err = 1; break; end
      @(negedge clk_i);
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_total++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

  initial begin
    bit gd, ge, me;
    int nw, w0;
    init_table();
    repeat (3) @(negedge clk_i);
    chk(cmd_ready_o == 1'b1, "R2", "reset ready", cmd_ready_o, 1);
    chk(done_o == 1'b0, "R5", "reset done", done_o, 0);
    chk(err_o == 1'b0, "R9", "reset err", err_o, 0);
    chk(mem_en_o == 1'b0, "R2", "reset mem_en", mem_en_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // vector walk: R3 R4 R5 R6 R9
    for (int v = 0; v < NV; v++) begin
      w0 = wr_cnt;
      ref_apply(V_START[v], NH_W'(V_NH[v]), me, nw);
      chk(me == bit'(V_ERR[v]), "R9", "model outcome", me, V_ERR[v]);
      issue(V_START[v], V_NH[v]);
      wait_end(gd, ge);
      chk(gd == !bit'(V_ERR[v]) && ge == bit'(V_ERR[v]), "R5", "done/err outcome", {gd, ge}, V_ERR[v] ? 1 : 2);
      if (gd) begin
        @(negedge clk_i);
        chk(done_o == 1'b0, "R5", "done one cycle", done_o, 0);
      end else begin
        @(negedge clk_i);
      end
      chk(wr_cnt - w0 == nw, "R3", "write count", wr_cnt - w0, nw);
      chk(table_diffs() == 0, "R4", "table vs model", table_diffs(), 0);
    end

    // R9: err cleared by next command; single-entry route R3
    chk(err_o == 1'b1, "R9", "err held", err_o, 1);
    ref_apply(10, NH_W'('h0aa), me, nw);
    issue(10, 'h0aa);
    chk(err_o == 1'b0, "R9", "err cleared", err_o, 0);
    wait_end(gd, ge);
    chk(gd == 1'b1, "R9", "done after err", gd, 1);
    @(negedge clk_i);
    chk(table_diffs() == 0, "R6", "single entry table", table_diffs(), 0);

    // R8 R10: lookups interleaved with a long scan
    ref_apply(0, NH_W'('h5a5), me, nw);
    issue(0, 'h5a5);
    @(negedge clk_i);
    lk_valid_i = 1'b1;
    lk_addr_i  = IDX_W'(60);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk_i);
      chk(lk_rvalid_o == 1'b1, "R8", "lookup valid", lk_rvalid_o, 1);
      chk(lk_nh_o == exp_mem[60][NH_W-1:0], "R8", "lookup data", lk_nh_o, exp_mem[60][NH_W-1:0]);
      chk(mem_we_o == 1'b0, "R8", "no write under lookup", mem_we_o, 0);
    end
    lk_addr_i = IDX_W'(33);
    @(negedge clk_i);
    chk(lk_nh_o == exp_mem[33][NH_W-1:0], "R8", "lookup addr change", lk_nh_o, exp_mem[33][NH_W-1:0]);
    lk_valid_i = 1'b0;
    @(negedge clk_i);
    chk(lk_rvalid_o == 1'b0, "R8", "lookup valid drop", lk_rvalid_o, 0);
    wait_end(gd, ge);
    chk(gd == 1'b1, "R10", "stalled scan done", gd, 1);
    @(negedge clk_i);
    chk(table_diffs() == 0, "R10", "table after stalls", table_diffs(), 0);
    chk(mem[0][ENT_W-1 -: 2] == 2'b01, "R1", "marker preserved", mem[0][ENT_W-1 -: 2], 1);

    finished = 1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule